// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at the 32 per-processor interrupt lines of one processor and picks the single interrupt that should be presented next. For each line it receives a pending bit, an enable bit, a group bit, a group-modifier bit and an 8-bit priority. It also receives three per-group enable bits. A line is a candidate only when it is pending, enabled, and the group it maps to is enabled. Among the candidates, the numerically smallest priority wins. When priorities are equal, the lowest interrupt number wins.

The search is a fully parallel tournament tree, and its result is registered. The result therefore reflects the inputs sampled at the previous rising clock edge. A coarse-priority input selects a mode in which only a 6-bit priority field counts. That field is scaled up to the 8-bit range, which matches how message-style interrupts express priority.

Top module: `hppi_select`

## Requirements
- R1: An interrupt line is a candidate only when its pending bit and its enable bit are both 1. A line missing either can never be the reported winner.
- R2: Each line maps to a group through {modifier, group}. 2'b00 maps to group-enable bit 0. 2'b10 maps to bit 1. 2'b01 and 2'b11 map to bit 2. A line whose mapped group-enable bit is 0 is not a candidate.
- R3: Among the candidates, the one with the numerically smallest effective priority is reported.
- R4: When several candidates share the smallest effective priority, the one with the lowest interrupt number is reported.
- R5: When `coarse_i` is 0, the effective priority is the line's 8-bit field. When it is 1, the effective priority is {field[5:0], 2'b00}. `prio_o` always reports the effective value.
- R6: When no candidate exists, `valid_o` is 0, `id_o` is 0 and `prio_o` is 8'hFF.
- R7: The outputs present the result for the inputs sampled at the previous rising edge of `clk`, which is exactly one cycle of latency.
- R8: While `rst` is high, and on the first cycle after it, the outputs are `valid_o`=0, `id_o`=0 and `prio_o`=8'hFF.
- R9: A candidate whose effective priority is 8'hFF is still reported, with `valid_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 32 | Per-line pending bits |
| en_i | input | 32 | Per-line enable bits |
| grp_i | input | 32 | Per-line group bit |
| grpmod_i | input | 32 | Per-line group-modifier bit |
| prio_i | input | 256 | Per-line 8-bit priority; line n occupies bits [8n+7:8n] |
| grp_en_i | input | 3 | Group enables: bit 0 group 0, bit 1 secure group 1, bit 2 non-secure group 1 |
| coarse_i | input | 1 | Selects 6-bit scaled priority mode |
| valid_o | output | 1 | A candidate exists |
| id_o | output | 5 | Winning interrupt number |
| prio_o | output | 8 | Winning effective priority, 8'hFF when idle |

## Verification
The block keeps no state other than its output register. A wrong qualification or a wrong tree comparison therefore shows at the ports on the very next cycle, as a wrong ID, a wrong priority or a wrong valid flag. The reference model recomputes the winner from the sampled inputs every cycle. Any divergence is caught within one clock of the stimulus that exposes it. The directed patterns target tie-breaking across distant IDs, each group encoding, the coarse mode and the idle encoding.

// File: rtl/hppi_pkg.sv
package hppi_pkg;
  localparam int NUM_IRQ  = 32;
  localparam int PRIO_W   = 8;
  localparam int NUM_GRP  = 3;
  localparam int COARSE_W = 6;

  // group-enable bit positions
  localparam int GE_G0    = 0;
  localparam int GE_G1SEC = 1;
  localparam int GE_G1NS  = 2;

  function automatic int unsigned grp_sel(input logic modifier, input logic grp);
    case ({modifier, grp})
      2'b00:   return GE_G0;
      2'b10:   return GE_G1SEC;
      default: return GE_G1NS;
    endcase
  endfunction
endpackage

// File: rtl/hppi_qual.sv
module hppi_qual
  import hppi_pkg::*;
#(
  parameter int N  = NUM_IRQ,
  parameter int PW = PRIO_W,
  parameter int CW = COARSE_W
) (
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      en_i,
  input  logic [N-1:0]      grp_i,
  input  logic [N-1:0]      grpmod_i,
  input  logic [N*PW-1:0]   prio_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic              coarse_i,
  output logic [N-1:0]      cand_o,
  output logic [N*PW-1:0]   eff_o
);
  localparam int SHIFT = PW - CW;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic ge;
    logic [PW-1:0] raw;
    assign raw = prio_i[i*PW +: PW];
    assign ge  = grp_en_i[grp_sel(grpmod_i[i], grp_i[i])];
    assign cand_o[i] = pend_i[i] & en_i[i] & ge;
    assign eff_o[i*PW +: PW] = coarse_i ? {raw[CW-1:0], {SHIFT{1'b0}}} : raw;
  end
endmodule

// File: rtl/hppi_tree.sv
module hppi_tree #(
  parameter int N   = 32,
  parameter int PW  = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     cand_i,
  input  logic [N*PW-1:0]  prio_i,
  output logic             win_vld_o,
  output logic [IDW-1:0]   win_id_o,
  output logic [PW-1:0]    win_prio_o
);
  localparam int LVL = $clog2(N);
  localparam int NP  = 1 << LVL;

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int W = NP >> l;
    logic [W-1:0]     v;
    logic [W*IDW-1:0] id;
    logic [W*PW-1:0]  pr;
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_n
        assign id[i*IDW +: IDW] = IDW'(i);
        if (i < N) begin : g_real
          assign v[i] = cand_i[i];
          assign pr[i*PW +: PW] = prio_i[i*PW +: PW];
        end else begin : g_pad
          assign v[i] = 1'b0;
          assign pr[i*PW +: PW] = '1;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_n
        logic lv, rv, take_l;
        logic [PW-1:0] lp, rp;
        assign lv = g_lvl[l-1].v[2*i];
        assign rv = g_lvl[l-1].v[2*i+1];
        assign lp = g_lvl[l-1].pr[(2*i)*PW +: PW];
        assign rp = g_lvl[l-1].pr[(2*i+1)*PW +: PW];
        // left branch holds the lower IDs, so it keeps ties
        assign take_l = lv & (~rv | (lp <= rp));
        assign v[i] = lv | rv;
        assign id[i*IDW +: IDW] = take_l ? g_lvl[l-1].id[(2*i)*IDW +: IDW]
                                         : g_lvl[l-1].id[(2*i+1)*IDW +: IDW];
        assign pr[i*PW +: PW] = take_l ? lp : rp;
      end
    end
  end

  assign win_vld_o  = g_lvl[LVL].v[0];
  assign win_id_o   = g_lvl[LVL].id[IDW-1:0];
  assign win_prio_o = g_lvl[LVL].pr[PW-1:0];

  // winner checks against every leaf
  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (cand_i[i]) begin
          p_best_prio_r3: assert (win_vld_o && win_prio_o <= prio_i[i*PW +: PW]);
          if (prio_i[i*PW +: PW] == win_prio_o) begin
            p_tie_low_id_r4: assert (int'(win_id_o) <= i);
          end
        end
      end
    end
  end
endmodule

// File: rtl/hppi_select.sv
module hppi_select
  import hppi_pkg::*;
#(
  parameter int N   = NUM_IRQ,
  parameter int PW  = PRIO_W,
  parameter int CW  = COARSE_W,
  parameter int IDW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       pend_i,
  input  logic [N-1:0]       en_i,
  input  logic [N-1:0]       grp_i,
  input  logic [N-1:0]       grpmod_i,
  input  logic [N*PW-1:0]    prio_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic               coarse_i,
  output logic               valid_o,
  output logic [IDW-1:0]     id_o,
  output logic [PW-1:0]      prio_o
);
  localparam logic [PW-1:0] IDLE_PRIO = '1;

  logic [N-1:0]    cand;
  logic [N*PW-1:0] eff;
  logic            w_vld;
  logic [IDW-1:0]  w_id;
  logic [PW-1:0]   w_prio;

  hppi_qual #(.N(N), .PW(PW), .CW(CW)) u_qual (
    .pend_i(pend_i), .en_i(en_i), .grp_i(grp_i), .grpmod_i(grpmod_i),
    .prio_i(prio_i), .grp_en_i(grp_en_i), .coarse_i(coarse_i),
    .cand_o(cand), .eff_o(eff)
  );

  hppi_tree #(.N(N), .PW(PW), .IDW(IDW)) u_tree (
    .clk(clk), .rst(rst), .cand_i(cand), .prio_i(eff),
    .win_vld_o(w_vld), .win_id_o(w_id), .win_prio_o(w_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      id_o    <= '0;
      prio_o  <= IDLE_PRIO;
    end else begin
      valid_o <= w_vld;
      id_o    <= w_vld ? w_id : '0;
      prio_o  <= w_vld ? w_prio : IDLE_PRIO;
    end
  end

  p_winner_qualified_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((($past(pend_i & en_i) >> id_o) & N'(1)) != '0));

  p_idle_code_r6: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (prio_o == IDLE_PRIO && id_o == '0));

  p_empty_invalid_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_i & en_i) == '0) |-> !valid_o);
endmodule

// File: tb/hppi_select_tb.sv
module hppi_select_tb;
  localparam int N = 32;
  localparam int PW = 8;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0] pend = '0, en = '0, grp = '0, gmod = '0;
  logic [N*PW-1:0] prio = '0;
  logic [2:0] gen = '0;
  logic coarse = 0;
  logic valid_o;
  logic [4:0] id_o;
  logic [7:0] prio_o;

  int total = 0, bad = 0;
  string cur_req = "R8";
  logic e_v; logic [4:0] e_id; logic [7:0] e_p;

  always #2.5 clk = ~clk;

  hppi_select u_dut (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .grp_i(grp),
    .grpmod_i(gmod), .prio_i(prio), .grp_en_i(gen), .coarse_i(coarse),
    .valid_o(valid_o), .id_o(id_o), .prio_o(prio_o)
  );

  // behavioural reference: linear scan, strict improvement only
  task automatic ref_eval(output logic v, output logic [4:0] id, output logic [7:0] p);
    v = 0; id = 0; p = 8'hFF;
    for (int i = 0; i < N; i++) begin
      logic [7:0] e;
      logic ge;
      e = coarse ? {prio[i*8 +: 6], 2'b00} : prio[i*8 +: 8];
      case ({gmod[i], grp[i]})
        2'b00: ge = gen[0];
        2'b10: ge = gen[1];
        default: ge = gen[2];
      endcase
      if (pend[i] && en[i] && ge && (!v || e < p)) begin
        v = 1; id = 5'(i); p = e;
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin e_v = 0; e_id = 0; e_p = 8'hFF; end
    else ref_eval(e_v, e_id, e_p);
  end

  task automatic check(string req);
    total++;
    if (valid_o !== e_v || id_o !== e_id || prio_o !== e_p) begin
      bad++;
      $display("FAIL %s: got v=%0b id=%0d p=%02h, exp v=%0b id=%0d p=%02h",
               req, valid_o, id_o, prio_o, e_v, e_id, e_p);
    end
  endtask

  // R7: compared every cycle, one register of latency
  always @(negedge clk) if (!rst) check({cur_req, "/R7"});

  task automatic setp(int i, logic [7:0] v); prio[i*8 +: 8] = v; endtask
  task automatic clear_all();
    pend = '0; en = '0; grp = '0; gmod = '0; prio = '0; coarse = 0; gen = 3'b111;
  endtask
  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  initial begin : watchdog
    #200000;
    total++; bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R8"; check("R8");
    rst = 0;
    @(negedge clk); cur_req = "R8";
    // R6 no candidates at all
    cur_req = "R6"; clear_all(); hold(3);
    // R1 pending without enable, and enable without pending
    cur_req = "R1"; pend[5] = 1; en[6] = 1; hold(2);
    en[5] = 1; setp(5, 8'h40); hold(2);
    // R2 each group encoding gated by its enable
    cur_req = "R2"; clear_all(); pend[9] = 1; en[9] = 1; setp(9, 8'h10);
    for (int enc = 0; enc < 4; enc++) begin
      {gmod[9], grp[9]} = 2'(enc);
      for (int g = 0; g < 8; g++) begin gen = 3'(g); hold(2); end
    end
    // R3 lower value wins regardless of ID
    cur_req = "R3"; clear_all(); pend = 32'hFFFF_FFFF; en = '1;
    for (int i = 0; i < N; i++) setp(i, 8'(200 - i));
    hold(2);
    setp(3, 8'h01); hold(2);
    // R4 ties go to lowest ID, including far-apart IDs
    cur_req = "R4"; clear_all(); pend[31] = 1; en[31] = 1; pend[0] = 1; en[0] = 1;
    setp(31, 8'h20); setp(0, 8'h20); hold(2);
    pend[0] = 0; pend[16] = 1; en[16] = 1; setp(16, 8'h20); hold(2);
    // R5 coarse mode scaling and tie created by it
    cur_req = "R5"; clear_all(); pend[2] = 1; en[2] = 1; pend[7] = 1; en[7] = 1;
    setp(2, 8'hC5); setp(7, 8'h12); hold(2);
    coarse = 1; hold(2);
    setp(7, 8'h05); hold(2);
    // R9 priority FF candidate still valid
    cur_req = "R9"; clear_all(); pend[30] = 1; en[30] = 1; setp(30, 8'hFF); hold(2);
    // random mixes
    cur_req = "R3R4R2";
    for (int k = 0; k < 400; k++) begin
      pend = $urandom; en = $urandom | $urandom; grp = $urandom; gmod = $urandom;
      gen = 3'($urandom); coarse = 1'($urandom);
      for (int i = 0; i < N; i++) setp(i, 8'($urandom_range(0, 7) * 37));
      hold(1);
    end
    // R8 reset mid-run
    cur_req = "R8"; rst = 1; hold(2); check("R8"); rst = 0; hold(1);
    cur_req = "R6"; clear_all(); hold(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule